// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with 64-bit Accumulator

This block performs 32-bit integer multiplication and division for a scalar processor pipeline. Results land in a dedicated 64-bit result pair, split into a high word and a low word. Multiply-accumulate and multiply-subtract operations update that pair in place, so a chain of products can be summed without touching the general registers. One multiply form skips the pair entirely and returns the low 32 bits of the product on the write-back port.

The pipeline issues a request as an opcode plus two operands. A request is accepted only on a clock edge where `busy` is low. A request that is still held when `busy` falls is accepted at that point. Reads of either half come back on the write-back port. Writes to either half load the word from operand A. Multiplies take two cycles. Divides use a radix-2 restoring loop that produces one quotient bit per cycle for 32 cycles.

Top module: `muldiv_acc`

## Requirements
- R1: After reset `busy` and `wb_valid` are 0, and both halves of the result pair read back as 0.
- R2: Opcodes 1 (signed) and 2 (unsigned) store the 64-bit product of A and B in the pair. `busy` is high for exactly the 2 cycles after acceptance.
- R3: Opcode 9 forms the signed product and drives its low 32 bits on `wb_data`, with `wb_valid` high in the second cycle after acceptance. The pair is left unchanged.
- R4: Opcodes 3 (signed) and 4 (unsigned) add the product to the pair's 64-bit value. The sum wraps modulo 2^64.
- R5: Opcodes 5 (signed) and 6 (unsigned) subtract the product from the pair's 64-bit value. The difference wraps modulo 2^64.
- R6: Opcodes 7 (signed) and 8 (unsigned) divide A by B and hold `busy` for 32 cycles. The quotient goes to the low half and the remainder to the high half. Signed division truncates toward zero, the remainder takes the sign of A, and 0x80000000 / -1 gives quotient 0x80000000 with remainder 0.
- R7: A divide by zero produces a low half of 0xFFFFFFFF and a high half equal to A, and raises nothing.
- R8: Opcodes 10 (high) and 11 (low) return that half on `wb_data`, with `wb_valid` high for one cycle, in the cycle after acceptance.
- R9: Opcodes 12 (high) and 13 (low) load operand A into that half in one cycle. A read accepted on the very next edge returns the new value.
- R10: A request presented while `busy` is high does nothing. A request held until `busy` falls is then accepted, and a read accepted this way returns the completed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_op | input | 4 | Operation code (see requirements) |
| opnd_a | input | 32 | Operand A / dividend / write data |
| opnd_b | input | 32 | Operand B / divisor |
| busy | output | 1 | Unit occupied; requests are not accepted |
| wb_valid | output | 1 | Write-back word valid (one cycle) |
| wb_data | output | 32 | Write-back word |

## Verification
Read results and direct-multiply results are registered. The bench therefore samples `wb_valid` and `wb_data` on the falling edge after the accepting edge for reads, and two falling edges later for opcode 9. For multiplies and divides, the bench counts the falling edges on which `busy` is high after acceptance and expects 2 or 32. It then checks the pair through reads held until `busy` falls. Each vector's expected pair comes from a 64-bit reference model kept in the bench, carried across the whole accumulation chain.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,  OP_MULS = 4'd1,  OP_MULU = 4'd2,
    OP_MACS = 4'd3,  OP_MACU = 4'd4,  OP_MSBS = 4'd5,
    OP_MSBU = 4'd6,  OP_DIVS = 4'd7,  OP_DIVU = 4'd8,
    OP_MLOW = 4'd9,  OP_RDHI = 4'd10, OP_RDLO = 4'd11,
    OP_WRHI = 4'd12, OP_WRLO = 4'd13
  } md_op_e;

  typedef enum logic [1:0] {
    K_SET = 2'd0, K_ADD = 2'd1, K_SUB = 2'd2, K_WB = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/muldiv_mul_pipe.sv
module muldiv_mul_pipe #(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_signed,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic              busy,
  output logic              prod_valid,
  output logic [2*XLEN-1:0] prod
);
  localparam int PW = 2 * XLEN;

  logic            s1_v_q, s1_sg_q;
  logic [XLEN-1:0] s1_a_q, s1_b_q;
  logic [PW-1:0]   ext_a, ext_b, prod_c, prod_q;
  logic            s2_v_q;

  always_comb begin
    ext_a  = {{XLEN{s1_sg_q & s1_a_q[XLEN-1]}}, s1_a_q};
    ext_b  = {{XLEN{s1_sg_q & s1_b_q[XLEN-1]}}, s1_b_q};
    prod_c = ext_a * ext_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0;
      s2_v_q <= 1'b0;
    end else begin
      s1_v_q <= start;
      s2_v_q <= s1_v_q;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      s1_a_q  <= a;
      s1_b_q  <= b;
      s1_sg_q <= is_signed;
    end
    if (s1_v_q) prod_q <= prod_c;
  end

  assign busy       = s1_v_q | s2_v_q;
  assign prod_valid = s2_v_q;
  assign prod       = prod_q;

  AST_MUL_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !prod_valid); // R2
  AST_MUL_TWO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ##1 prod_valid); // R2
endmodule

// File: rtl/muldiv_div_iter.sv
module muldiv_div_iter #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_signed,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] quo,
  output logic [XLEN-1:0] rem
);
  localparam int CW = $clog2(XLEN + 1);

  logic            act_q, act_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [XLEN-1:0] rem_q, rem_d, quo_q, quo_d, dvs_q, dvs_d, dvd_q, dvd_d;
  logic            qneg_q, qneg_d, rneg_q, rneg_d, dz_q, dz_d;
  logic [XLEN:0]   shifted, diff;
  logic            fits;
  logic [XLEN-1:0] rem_n, quo_n;

  always_comb begin
    shifted = {rem_q, quo_q[XLEN-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = ~diff[XLEN];
    rem_n   = fits ? diff[XLEN-1:0] : shifted[XLEN-1:0];
    quo_n   = {quo_q[XLEN-2:0], fits};
    done    = act_q && (cnt_q == CW'(1));
    quo     = dz_q ? {XLEN{1'b1}} : (qneg_q ? -quo_n : quo_n);
    rem     = dz_q ? dvd_q : (rneg_q ? -rem_n : rem_n);
  end

  always_comb begin
    act_d = act_q; cnt_d = cnt_q; rem_d = rem_q; quo_d = quo_q;
    dvs_d = dvs_q; dvd_d = dvd_q; qneg_d = qneg_q; rneg_d = rneg_q; dz_d = dz_q;
    if (start) begin
      act_d  = 1'b1;
      cnt_d  = CW'(XLEN);
      rem_d  = '0;
      quo_d  = (is_signed && a[XLEN-1]) ? -a : a;
      dvs_d  = (is_signed && b[XLEN-1]) ? -b : b;
      dvd_d  = a;
      qneg_d = is_signed && (a[XLEN-1] ^ b[XLEN-1]);
      rneg_d = is_signed && a[XLEN-1];
      dz_d   = (b == '0);
    end else if (act_q) begin
      cnt_d = cnt_q - CW'(1);
      rem_d = rem_n;
      quo_d = quo_n;
      if (done) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start || act_q) begin
      rem_q <= rem_d; quo_q <= quo_d; dvs_q <= dvs_d; dvd_q <= dvd_d;
      qneg_q <= qneg_d; rneg_q <= rneg_d; dz_q <= dz_d;
    end
  end

  assign busy = act_q;

  AST_DIV_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (cnt_q != '0) && (cnt_q <= CW'(XLEN))); // R6
  AST_DIV_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> act_q && (cnt_q == CW'(XLEN))); // R6
endmodule

// File: rtl/muldiv_acc.sv
module muldiv_acc
  import muldiv_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [3:0]      req_op,
  input  logic [31:0]     opnd_a,
  input  logic [31:0]     opnd_b,
  output logic            busy,
  output logic            wb_valid,
  output logic [31:0]     wb_data
);
  localparam int PW = 2 * XLEN;

  logic        rst_meta_q, rst_s_n;
  logic        accept, mul_start, div_start, op_signed;
  logic        mul_busy, prod_valid, div_busy, div_done;
  logic [PW-1:0]   prod;
  logic [XLEN-1:0] dq, dr;
  logic [XLEN-1:0] hi_q, hi_d, lo_q, lo_d, wbd_q, wbd_d;
  logic            hilo_en, wbv_q, wbv_d;
  acc_kind_e       kind_q, kind_d;
  md_op_e          op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  assign op        = md_op_e'(req_op);
  assign busy      = mul_busy | div_busy;
  assign accept    = req_valid & ~busy;
  assign op_signed = (op == OP_MULS) || (op == OP_MACS) || (op == OP_MSBS) ||
                     (op == OP_DIVS) || (op == OP_MLOW);
  assign mul_start = accept && (op inside {OP_MULS, OP_MULU, OP_MACS, OP_MACU,
                                           OP_MSBS, OP_MSBU, OP_MLOW});
  assign div_start = accept && (op inside {OP_DIVS, OP_DIVU});

  muldiv_mul_pipe #(.XLEN(XLEN)) mul_i (
    .clk(clk), .rst_n(rst_s_n), .start(mul_start), .is_signed(op_signed),
    .a(opnd_a), .b(opnd_b), .busy(mul_busy), .prod_valid(prod_valid), .prod(prod)
  );

  muldiv_div_iter #(.XLEN(XLEN)) div_i (
    .clk(clk), .rst_n(rst_s_n), .start(div_start), .is_signed(op_signed),
    .a(opnd_a), .b(opnd_b), .busy(div_busy), .done(div_done), .quo(dq), .rem(dr)
  );

  always_comb begin
    kind_d = kind_q;
    if (mul_start) begin
      unique case (op)
        OP_MACS, OP_MACU: kind_d = K_ADD;
        OP_MSBS, OP_MSBU: kind_d = K_SUB;
        OP_MLOW:          kind_d = K_WB;
        default:          kind_d = K_SET;
      endcase
    end
  end

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    wbv_d = 1'b0;
    wbd_d = wbd_q;
    if (prod_valid) begin
      unique case (kind_q)
        K_ADD:   {hi_d, lo_d} = {hi_q, lo_q} + prod;
        K_SUB:   {hi_d, lo_d} = {hi_q, lo_q} - prod;
        K_WB:    begin wbv_d = 1'b1; wbd_d = prod[XLEN-1:0]; end
        default: {hi_d, lo_d} = prod;
      endcase
    end
    if (div_done) {hi_d, lo_d} = {dr, dq};
    if (accept) begin
      unique case (op)
        OP_RDHI: begin wbv_d = 1'b1; wbd_d = hi_q; end
        OP_RDLO: begin wbv_d = 1'b1; wbd_d = lo_q; end
        OP_WRHI: hi_d = opnd_a;
        OP_WRLO: lo_d = opnd_a;
        default: ;
      endcase
    end
  end

  assign hilo_en = prod_valid | div_done | accept;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      wbv_q  <= 1'b0;
      wbd_q  <= '0;
      kind_q <= K_SET;
    end else begin
      if (hilo_en) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
      wbv_q <= wbv_d;
      if (wbv_d) wbd_q <= wbd_d;
      if (mul_start) kind_q <= kind_d;
    end
  end

  assign wb_valid = wbv_q;
  assign wb_data  = wbd_q;

  AST_PAIR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && !prod_valid && !div_done) |=> $stable({hi_q, lo_q})); // R10
  AST_WRLO_ONE_CYC: assert property (@(posedge clk) disable iff (!rst_s_n)
    (req_valid && !busy && req_op == 4'd13) |=> lo_q == $past(opnd_a)); // R9
  AST_WB_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    wb_valid |-> !busy); // R8
  AST_MLOW_PAIR_KEPT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (prod_valid && kind_q == K_WB) |=> $stable({hi_q, lo_q})); // R3
  AST_NO_TWO_ENGINES: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(mul_busy && div_busy)); // R10
endmodule

// File: tb/muldiv_acc_tb.sv
`timescale 1ns/1ps
module muldiv_acc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [31:0] opnd_a, opnd_b;
  logic        busy, wb_valid;
  logic [31:0] wb_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [63:0] mdl;

  always #2.5 clk = ~clk;

  muldiv_acc dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .wb_valid(wb_valid),
    .wb_data(wb_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  localparam int NV = 20;
  localparam logic [67:0] VEC [0:NV-1] = '{
    {4'd2,  32'hFFFFFFFF, 32'hFFFFFFFF},
    {4'd1,  32'hFFFFFFFF, 32'hFFFFFFFF},
    {4'd1,  32'h80000000, 32'h80000000},
    {4'd3,  32'h7FFFFFFF, 32'h7FFFFFFF},
    {4'd4,  32'hFFFFFFFF, 32'hFFFFFFFF},
    {4'd5,  32'h80000000, 32'h7FFFFFFF},
    {4'd6,  32'h12345678, 32'h9ABCDEF0},
    {4'd12, 32'h7FFFFFFF, 32'h00000000},
    {4'd13, 32'hFFFFFFFF, 32'h00000000},
    {4'd4,  32'h00000001, 32'h00000001},
    {4'd5,  32'hFFFFFFFF, 32'h00000001},
    {4'd9,  32'h00010000, 32'h00010000},
    {4'd9,  32'hFFFFFFFE, 32'h00000003},
    {4'd7,  32'hFFFFFFF9, 32'h00000002},
    {4'd8,  32'hFFFFFFF9, 32'h00000002},
    {4'd7,  32'h80000000, 32'hFFFFFFFF},
    {4'd7,  32'h00000007, 32'hFFFFFFFE},
    {4'd8,  32'h00001234, 32'h00000000},
    {4'd7,  32'hFFFFFF00, 32'h00000000},
    {4'd5,  32'h00000000, 32'h00000000}
  };

  function automatic string req_of(input logic [3:0] op, input logic [31:0] b);
    case (op)
      4'd1, 4'd2:   return "R2";
      4'd3, 4'd4:   return "R4";
      4'd5, 4'd6:   return "R5";
      4'd7, 4'd8:   return (b == 0) ? "R7" : "R6";
      4'd9:         return "R3";
      default:      return "R9";
    endcase
  endfunction

  function automatic logic [63:0] ref_prod(input logic [3:0] op,
                                           input logic [31:0] a, b);
    longint sa, sb;
    logic [63:0] ua, ub;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = {32'd0, a};           ub = {32'd0, b};
    if (op == 4'd1 || op == 4'd3 || op == 4'd5 || op == 4'd9) return 64'(sa * sb);
    return ua * ub;
  endfunction

  function automatic logic [63:0] ref_next(input logic [3:0] op,
                                           input logic [31:0] a, b,
                                           input logic [63:0] cur);
    longint sa, sb;
    logic [63:0] q, r;
    case (op)
      4'd1, 4'd2: return ref_prod(op, a, b);
      4'd3, 4'd4: return cur + ref_prod(op, a, b);
      4'd5, 4'd6: return cur - ref_prod(op, a, b);
      4'd7, 4'd8: begin
        if (b == 0) return {a, 32'hFFFFFFFF};
        if (op == 4'd7) begin
          sa = longint'($signed(a)); sb = longint'($signed(b));
          q = 64'(sa / sb); r = 64'(sa % sb);
        end else begin
          q = {32'd0, a} / {32'd0, b}; r = {32'd0, a} % {32'd0, b};
        end
        return {r[31:0], q[31:0]};
      end
      4'd12:   return {a, cur[31:0]};
      4'd13:   return {cur[63:32], a};
      default: return cur;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic issue(input logic [3:0] op, input logic [31:0] a, b);
    logic acc;
    req_valid = 1'b1; req_op = op; opnd_a = a; opnd_b = b;
    forever begin
      acc = !busy;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0; req_op = 4'd0;
  endtask

  task automatic read_half(input bit hi, input string req, input logic [31:0] exp);
    issue(hi ? 4'd10 : 4'd11, 32'd0, 32'd0);
    chk(req, {31'd0, wb_valid}, 32'd1);
    chk(req, wb_data, exp);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    logic [63:0] nx;
    rst_n = 1'b0; req_valid = 1'b0; req_op = 4'd0; opnd_a = '0; opnd_b = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", {30'd0, busy, wb_valid}, 32'd0);
    read_half(1'b1, "R1", 32'd0);
    read_half(1'b0, "R1", 32'd0);
    mdl = 64'd0;

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      string rq;
      {op, a, b} = VEC[i];
      rq = req_of(op, b);
      issue(op, a, b);
      if (op == 4'd9) begin
        chk("R3", {31'd0, wb_valid}, 32'd0);
        @(negedge clk);
        chk("R3", {31'd0, wb_valid}, 32'd0);
        @(negedge clk);
        chk("R3", {31'd0, wb_valid}, 32'd1);
        chk("R3", wb_data, ref_prod(op, a, b) >> 0 & 64'hFFFFFFFF);
      end
      mdl = ref_next(op, a, b, mdl);
      read_half(1'b1, rq, mdl[63:32]);
      read_half(1'b0, rq, mdl[31:0]);
    end

    // R2 latency
    issue(4'd2, 32'd3, 32'd5);
    busy_len(n);
    chk("R2", n, 32'd2);
    mdl = 64'd15;
    read_half(1'b0, "R2", 32'd15);

    // R6 latency
    issue(4'd8, 32'd1000, 32'd7);
    busy_len(n);
    chk("R6", n, 32'd32);
    read_half(1'b0, "R6", 32'd142);
    read_half(1'b1, "R6", 32'd6);

    // R9 write then immediate read
    issue(4'd13, 32'hCAFEF00D, 32'd0);
    issue(4'd11, 32'd0, 32'd0);
    chk("R9", wb_data, 32'hCAFEF00D);

    // R10 write during busy ignored; read held through busy gets completed result
    issue(4'd8, 32'd100, 32'd7);
    req_valid = 1'b1; req_op = 4'd12; opnd_a = 32'hDEADBEEF;
    @(negedge clk);
    req_valid = 1'b0; req_op = 4'd0;
    chk("R10", {31'd0, busy}, 32'd1);
    read_half(1'b1, "R10", 32'd2);
    read_half(1'b0, "R10", 32'd14);

    // R10 signed accumulation after stall chain
    issue(4'd12, 32'h00000000, 32'd0);
    issue(4'd13, 32'h00000000, 32'd0);
    issue(4'd3, 32'hFFFFFFFF, 32'h00000001);
    issue(4'd3, 32'hFFFFFFFF, 32'h00000001);
    nx = 64'hFFFFFFFFFFFFFFFE;
    read_half(1'b1, "R4", nx[63:32]);
    read_half(1'b0, "R4", nx[31:0]);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule